// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block is a single programmable chip-select channel on a 24-bit address bus. Two registers describe it. The base register holds the upper address lines of the window and a three-bit size code. The option register holds the qualifiers that a bus cycle must meet. On each cycle the channel compares the upper address lines it has been told to compare, checks direction, byte lane, address space and interrupt level, and then takes one of three actions: it drives an active-low select with a locally timed data-size acknowledge, it raises a request for a synchronous E-clock cycle, or it answers an interrupt acknowledge with an autovector strobe.

The response sequencing lives in a state machine. IDLE waits for a qualified strobe. From IDLE, a hit goes to one of these states:
- SYNC when the channel is synchronous.
- AVEC when an autovector is due.
- HOLD when the acknowledge comes from outside.
- ACK when fast termination is selected.
- WAIT otherwise. WAIT loads the programmed wait-state count and counts it down, then goes to ACK when the count reaches zero.

Every state other than IDLE returns to IDLE on the clock edge that samples the address strobe high. The channel can be built as the boot variant through the `BOOT` parameter. That variant leaves reset already decoding a 1 MB window at address zero.

Top module: `csel_channel`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, `wr_sel`=0 loads the base register and `wr_sel`=1 loads the option register. The base register is laid out as bits [15:3] = ADDR[23:11] and bits [2:0] = size code. The option register is laid out as mode[15], lane[14:13], dir[12:11], strobe[10], ack[9:6], space[5:4], level[3:1], avec[0]. With `wr_en` low, neither register changes.
- R2: Size codes 0 to 7 select windows of 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M. Those sizes compare ADDR[23:11], [23:13], [23:14], [23:16], [23:17], [23:18], [23:19] and [23:20] against the matching base bits. Lower address bits are ignored.
- R3: Direction code 00 never matches, 01 matches reads only (`rw`=1), 10 matches writes only (`rw`=0), and 11 matches both directions.
- R4: When `port16`=1, lane code 00 never matches. Lane code 01 matches when ADDR[0]=1 or `word`=1. Lane code 10 matches when ADDR[0]=0. Lane code 11 always matches. When `port16`=0, the lane code has no effect.
- R5: Space code 00 matches only CPU-space cycles (`cpu_space`=1). Outside CPU space, 01 matches user cycles (`sup`=0), 10 matches supervisor cycles, and 11 matches both.
- R6: In CPU-space cycles, level code 000 matches any `iack_lvl`, and any other level code must equal `iack_lvl`.
- R7: The strobe bit selects the strobe that qualifies a hit: 0 selects `as_n`, 1 selects `ds_n`. The response appears on the first clock edge at which a hit, a low `as_n` and the selected strobe are all sampled together.
- R8: In asynchronous mode (mode=0), `cs_n` falls at that edge. Ack codes 0 to 13 make `dsack_n` fall that many cycles plus one after `cs_n` falls. Code 14 makes `dsack_n` fall together with `cs_n`. Code 15 never asserts `dsack_n`.
- R9: In synchronous mode (mode=1), a qualified hit raises `eclk_req`, and `cs_n` and `dsack_n` stay high.
- R10: In a CPU-space hit with avec=1, `avec_n` falls instead of `cs_n` and no acknowledge is produced. With avec=0, such a hit selects normally.
- R11: Outputs hold until the edge that samples `as_n` high, and are all inactive one edge later.
- R12: After reset, the boot variant decodes a 1M window at address 0 in either direction, with 13 wait states and any lane or space other than CPU space. The other variant never matches after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = base register, 1 = option register |
| wr_data | input | 16 | Register write data |
| addr | input | 24 | Bus address |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| word | input | 1 | 1 = word-sized access |
| sup | input | 1 | 1 = supervisor cycle |
| cpu_space | input | 1 | 1 = CPU-space (interrupt acknowledge) cycle |
| iack_lvl | input | 3 | Level being acknowledged |
| port16 | input | 1 | 1 = channel drives a 16-bit port |
| cs_n | output | 1 | Chip select, active low |
| dsack_n | output | 1 | Locally generated acknowledge, active low |
| avec_n | output | 1 | Autovector acknowledge, active low |
| eclk_req | output | 1 | Synchronous E-clock cycle pending |

## Verification
The bench aims at the first and last address inside each window size and at the first address beyond it. A compare mask that is off by one bit would accept the neighbouring block, or reject the top of its own. It sweeps the wait count across 0, 2, 13, fast and external, so that an acknowledge one cycle early, one cycle late, or produced when it should be suppressed shows up at a precise cycle. It also sets the lane field against `port16`, delays `ds_n` under the data-strobe option, and sets levels against the autovector enable. These cases expose a design that ignores its qualifiers or selects a part during an autovector answer.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_HOLD,
        ST_AVEC,
        ST_SYNC
    } cs_state_e;

    typedef struct packed {
        logic       mode;
        logic [1:0] lane;
        logic [1:0] dir;
        logic       strb;
        logic [3:0] ack;
        logic [1:0] space;
        logic [2:0] ipl;
        logic       avec;
    } opt_t;

    localparam logic [3:0] ACK_FAST = 4'hE;
    localparam logic [3:0] ACK_EXT  = 4'hF;

    localparam logic [15:0] BOOT_OPT  = 16'h7B70;
    localparam logic [2:0]  BOOT_SIZE = 3'b111;

endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int FIELD_W = 13,
    parameter int DATA_W  = 16,
    parameter bit BOOT    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [FIELD_W-1:0] base_q,
    output logic [2:0]         size_q,
    output opt_t               opt_q
);

    localparam logic [15:0] OPT_RST  = BOOT ? BOOT_OPT  : 16'h0000;
    localparam logic [2:0]  SIZE_RST = BOOT ? BOOT_SIZE : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= SIZE_RST;
            opt_q  <= opt_t'(OPT_RST);
        end else if (wr_en) begin
            if (wr_sel) begin
                opt_q <= opt_t'(wr_data[15:0]);
            end else begin
                base_q <= wr_data[FIELD_W+2:3];
                size_q <= wr_data[2:0];
            end
        end
    end

endmodule

// File: rtl/csel_match.sv
module csel_match #(
    parameter int ADDR_W  = 24,
    parameter int LOW_BIT = 11
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-LOW_BIT-1:0] base_q,
    input  logic [2:0]                size_q,
    input  logic [1:0]                lane,
    input  logic [1:0]                dir,
    input  logic [1:0]                space,
    input  logic [2:0]                ipl,
    input  logic                      rw,
    input  logic                      word,
    input  logic                      port16,
    input  logic                      sup,
    input  logic                      cpu_space,
    input  logic [2:0]                iack_lvl,
    output logic                      hit
);

    localparam int FIELD_W = ADDR_W - LOW_BIT;
    localparam int SH_W    = $clog2(FIELD_W + 1);

    logic [SH_W-1:0]    shift;
    logic [FIELD_W-1:0] eq;
    logic addr_ok, dir_ok, lane_ok, space_ok, lvl_ok;
    logic unused_addr;

    assign unused_addr = ^addr[LOW_BIT-1:1];

    always_comb begin
        unique case (size_q)
            3'd0: shift = SH_W'(0);
            3'd1: shift = SH_W'(2);
            3'd2: shift = SH_W'(3);
            3'd3: shift = SH_W'(5);
            3'd4: shift = SH_W'(6);
            3'd5: shift = SH_W'(7);
            3'd6: shift = SH_W'(8);
            default: shift = SH_W'(9);
        endcase
    end

    for (genvar i = 0; i < FIELD_W; i++) begin : g_cmp
        assign eq[i] = (SH_W'(i) < shift) || (addr[LOW_BIT+i] == base_q[i]);
    end

    assign addr_ok = &eq;

    always_comb begin
        unique case (dir)
            2'b00: dir_ok = 1'b0;
            2'b01: dir_ok = rw;
            2'b10: dir_ok = !rw;
            default: dir_ok = 1'b1;
        endcase
    end

    always_comb begin
        if (!port16) begin
            lane_ok = 1'b1;
        end else begin
            unique case (lane)
                2'b00: lane_ok = 1'b0;
                2'b01: lane_ok = addr[0] || word;
                2'b10: lane_ok = !addr[0];
                default: lane_ok = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (cpu_space) begin
            space_ok = (space == 2'b00);
        end else begin
            unique case (space)
                2'b00: space_ok = 1'b0;
                2'b01: space_ok = !sup;
                2'b10: space_ok = sup;
                default: space_ok = 1'b1;
            endcase
        end
    end

    assign lvl_ok = !cpu_space || (ipl == 3'b000) || (ipl == iack_lvl);

    assign hit = addr_ok && dir_ok && lane_ok && space_ok && lvl_ok;

endmodule

// File: rtl/csel_fsm.sv
module csel_fsm
    import csel_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              bus_end,
    input  logic              sync_mode,
    input  logic              avec_sel,
    input  logic [WAIT_W-1:0] ack_code,
    output logic              cs_n,
    output logic              dsack_n,
    output logic              avec_n,
    output logic              eclk_req
);

    cs_state_e         st, nxt;
    logic [WAIT_W-1:0] cnt, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_d;
        end
    end

    always_comb begin
        nxt   = st;
        cnt_d = cnt;
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    if (sync_mode)                       nxt = ST_SYNC;
                    else if (avec_sel)                   nxt = ST_AVEC;
                    else if (ack_code == WAIT_W'(ACK_EXT))  nxt = ST_HOLD;
                    else if (ack_code == WAIT_W'(ACK_FAST)) nxt = ST_ACK;
                    else begin
                        nxt   = ST_WAIT;
                        cnt_d = ack_code;
                    end
                end
            end
            ST_WAIT: begin
                if (bus_end)       nxt = ST_IDLE;
                else if (cnt == '0) nxt = ST_ACK;
                else               cnt_d = cnt - 1'b1;
            end
            ST_ACK, ST_HOLD, ST_AVEC, ST_SYNC: begin
                if (bus_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cs_n     = 1'b1;
        dsack_n  = 1'b1;
        avec_n   = 1'b1;
        eclk_req = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_WAIT, ST_HOLD: cs_n = 1'b0;
            ST_ACK: begin
                cs_n    = 1'b0;
                dsack_n = 1'b0;
            end
            ST_AVEC: avec_n   = 1'b0;
            ST_SYNC: eclk_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/csel_channel.sv
module csel_channel
    import csel_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LOW_BIT = 11,
    parameter int DATA_W  = 16,
    parameter bit BOOT    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              word,
    input  logic              sup,
    input  logic              cpu_space,
    input  logic [2:0]        iack_lvl,
    input  logic              port16,
    output logic              cs_n,
    output logic              dsack_n,
    output logic              avec_n,
    output logic              eclk_req
);

    localparam int FIELD_W = ADDR_W - LOW_BIT;

    logic [FIELD_W-1:0] base_q;
    logic [2:0]         size_q;
    opt_t               opt_q;
    logic               hit, strobe, go;

    csel_regs #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .BOOT(BOOT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .base_q  (base_q),
        .size_q  (size_q),
        .opt_q   (opt_q)
    );

    csel_match #(.ADDR_W(ADDR_W), .LOW_BIT(LOW_BIT)) u_match (
        .addr      (addr),
        .base_q    (base_q),
        .size_q    (size_q),
        .lane      (opt_q.lane),
        .dir       (opt_q.dir),
        .space     (opt_q.space),
        .ipl       (opt_q.ipl),
        .rw        (rw),
        .word      (word),
        .port16    (port16),
        .sup       (sup),
        .cpu_space (cpu_space),
        .iack_lvl  (iack_lvl),
        .hit       (hit)
    );

    assign strobe = opt_q.strb ? !ds_n : !as_n;
    assign go     = hit && strobe && !as_n;

    csel_fsm #(.WAIT_W(4)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .bus_end   (as_n),
        .sync_mode (opt_q.mode),
        .avec_sel  (opt_q.avec && cpu_space),
        .ack_code  (opt_q.ack),
        .cs_n      (cs_n),
        .dsack_n   (dsack_n),
        .avec_n    (avec_n),
        .eclk_req  (eclk_req)
    );

endmodule

// File: rtl/csel_channel_chk.sv
module csel_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic cs_n,
    input logic dsack_n,
    input logic avec_n,
    input logic eclk_req
);

    // R9
    sync_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eclk_req |-> (cs_n && dsack_n));

    // R10
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!cs_n, !avec_n, eclk_req}));

    // R8
    ack_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dsack_n |-> !cs_n);

    // R11
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsack_n && !as_n) |=> !dsack_n);

    // R11
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (cs_n && dsack_n && avec_n && !eclk_req));

endmodule

bind csel_channel csel_channel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n),
    .cs_n     (cs_n),
    .dsack_n  (dsack_n),
    .avec_n   (avec_n),
    .eclk_req (eclk_req)
);

// File: tb/test_csel_channel.sv
`timescale 1ns/1ps
module test_csel_channel;

    localparam int L      = 20;
    localparam int K_NONE = 0;
    localparam int K_CS   = 1;
    localparam int K_AV   = 2;
    localparam int K_SYNC = 3;
    localparam int N_FAST = -1;
    localparam int N_EXT  = -2;

    typedef struct {
        int    s;
        int    kind;
        int    n;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, word = 1'b1;
    logic        sup = 1'b1, cpu_space = 1'b0, port16 = 1'b0;
    logic [2:0]  iack_lvl = '0;
    logic        cs_n, dsack_n, avec_n, eclk_req;

    int tests = 0;
    int fails = 0;
    item_t q[$];

    always #4 clk = ~clk;

    csel_channel #(.BOOT(1'b1)) i_csel_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr(addr), .as_n(as_n), .ds_n(ds_n), .rw(rw), .word(word), .sup(sup),
        .cpu_space(cpu_space), .iack_lvl(iack_lvl), .port16(port16),
        .cs_n(cs_n), .dsack_n(dsack_n), .avec_n(avec_n), .eclk_req(eclk_req)
    );

    function automatic logic [15:0] opt(input logic m, input logic [1:0] ln, input logic [1:0] d,
                                        input logic sb, input logic [3:0] ak, input logic [1:0] sp,
                                        input logic [2:0] lv, input logic av);
        return {m, ln, d, sb, ak, sp, lv, av};
    endfunction

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp_v);
        tests++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: {cs_n,dsack_n,avec_n,eclk_req} actual %b expected %b", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input logic [23:0] a, input logic rd, input logic wd, input logic sp,
                       input logic cpu, input logic [2:0] lv, input int s, input int kind,
                       input int n, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; rw = rd; word = wd; sup = sp; cpu_space = cpu; iack_lvl = lv;
        as_n = 1'b0;
        ds_n = (s == 0) ? 1'b0 : 1'b1;
        it.s = s; it.kind = kind; it.n = n; it.tag = tag;
        q.push_back(it);
        for (int i = 1; i <= L; i++) begin
            @(negedge clk);
            if (i == s) ds_n = 1'b0;
        end
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: idle one edge after strobe release
        check4({tag, " R11 idle"}, {cs_n, dsack_n, avec_n, eclk_req}, 4'b1110);
    endtask

    // monitor: pops expected items and compares each cycle of the bus cycle
    initial begin
        forever begin
            item_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            for (int i = 1; i <= L; i++) begin
                logic on, e_cs, e_ack, e_av, e_ec;
                @(negedge clk);
                #1;
                on    = (it.kind != K_NONE) && (i >= it.s + 1);
                e_cs  = on && (it.kind == K_CS);
                e_ack = e_cs && (it.n != N_EXT) && (i >= it.s + 2 + it.n);
                e_av  = on && (it.kind == K_AV);
                e_ec  = on && (it.kind == K_SYNC);
                check4($sformatf("%s cyc%0d", it.tag, i), {cs_n, dsack_n, avec_n, eclk_req},
                       {!e_cs, !e_ack, !e_av, e_ec});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check4("R12 reset", {cs_n, dsack_n, avec_n, eclk_req}, 4'b1110);
        rst_n = 1'b1;

        // R12 boot window from reset
        run(24'h012345, 1, 1, 1, 0, 0, 0, K_CS, 13, "R12 boot hit");
        run(24'h012345, 0, 1, 0, 0, 0, 0, K_CS, 13, "R12 boot user write");
        run(24'h100000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R12 boot miss");

        // R1 base 0x200000 size 64K, async 2 waits
        wr(0, 16'h2003);
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h20FFFE, 1, 1, 1, 0, 0, 0, K_CS, 2, "R1 R2 R8 64K top");
        run(24'h210000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R2 64K beyond");
        run(24'h1FFFFF, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R2 64K below");

        // R1 write disabled: no change
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b1; wr_data = 16'h0000;
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 2, "R1 no write");

        wr(0, 16'h2000);
        run(24'h2007FF, 1, 1, 1, 0, 0, 0, K_CS, 2, "R2 2K top");
        run(24'h200800, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R2 2K beyond");
        wr(0, 16'h2007);
        run(24'h2FFFFF, 1, 1, 1, 0, 0, 0, K_CS, 2, "R2 1M top");
        run(24'h300000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R2 1M beyond");
        wr(0, 16'h2004);
        run(24'h21FFFF, 1, 1, 1, 0, 0, 0, K_CS, 2, "R2 128K top");
        run(24'h220000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R2 128K beyond");

        // R3 direction
        wr(1, opt(0, 2'b11, 2'b01, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200010, 0, 1, 1, 0, 0, 0, K_NONE, 0, "R3 read-only write");
        run(24'h200010, 1, 1, 1, 0, 0, 0, K_CS, 2, "R3 read-only read");
        wr(1, opt(0, 2'b11, 2'b10, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200010, 0, 1, 1, 0, 0, 0, K_CS, 2, "R3 write-only write");
        run(24'h200010, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R3 write-only read");
        wr(1, opt(0, 2'b11, 2'b00, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200010, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R3 reserved");

        // R4 byte lanes
        port16 = 1'b1;
        wr(1, opt(0, 2'b01, 2'b11, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200001, 1, 0, 1, 0, 0, 0, K_CS, 2, "R4 lower odd byte");
        run(24'h200000, 1, 0, 1, 0, 0, 0, K_NONE, 0, "R4 lower even byte");
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 2, "R4 lower word");
        wr(1, opt(0, 2'b10, 2'b11, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200001, 1, 0, 1, 0, 0, 0, K_NONE, 0, "R4 upper odd");
        run(24'h200000, 1, 0, 1, 0, 0, 0, K_CS, 2, "R4 upper even");
        wr(1, opt(0, 2'b00, 2'b11, 0, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R4 lanes off");
        port16 = 1'b0;
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 2, "R4 8-bit port ignores lane");

        // R5 space
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd2, 2'b10, 3'd0, 0));
        run(24'h200000, 1, 1, 0, 0, 0, 0, K_NONE, 0, "R5 sup-only user");
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 2, "R5 sup-only sup");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd2, 2'b01, 3'd0, 0));
        run(24'h200000, 1, 1, 0, 0, 0, 0, K_CS, 2, "R5 user-only user");
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_NONE, 0, "R5 user-only sup");

        // R7 data-strobe qualified
        wr(1, opt(0, 2'b11, 2'b11, 1, 4'd2, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 2, K_CS, 2, "R7 data strobe");

        // R8 wait states
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd0, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 0, "R8 zero waits");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd13, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, 13, "R8 thirteen waits");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd14, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, N_FAST, "R8 fast");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd15, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_CS, N_EXT, "R8 external");

        // R9 synchronous
        wr(1, opt(1, 2'b11, 2'b11, 0, 4'd3, 2'b11, 3'd0, 0));
        run(24'h200000, 1, 1, 1, 0, 0, 0, K_SYNC, 0, "R9 sync");

        // R6 R10 interrupt acknowledge
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd1, 2'b00, 3'd5, 1));
        run(24'h200000, 1, 1, 1, 1, 3'd5, 0, K_AV, 0, "R6 R10 level match avec");
        run(24'h200000, 1, 1, 1, 1, 3'd3, 0, K_NONE, 0, "R6 level mismatch");
        run(24'h200000, 1, 1, 1, 0, 3'd5, 0, K_NONE, 0, "R5 cpu-space code normal cycle");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd1, 2'b00, 3'd0, 1));
        run(24'h200000, 1, 1, 1, 1, 3'd3, 0, K_AV, 0, "R6 any level");
        wr(1, opt(0, 2'b11, 2'b11, 0, 4'd1, 2'b00, 3'd5, 0));
        run(24'h200000, 1, 1, 1, 1, 3'd5, 0, K_CS, 1, "R10 avec off selects");

        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule